// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block works out which instruction a small processor fetches next. Each time the advance strobe is high it takes one decoded control-flow operation and moves the program counter on: to the next instruction, to a relative target if a flag test passes, to an absolute address for a jump, or to a subroutine address for a call. A return takes its address from a hardware pushdown stack of return addresses that calls fill.

The decoder that feeds the block supplies the operation code, a signed displacement, an absolute target and the current zero and carry flags. The block holds the program counter and a sticky error flag. The error flag marks a call made with the stack already full or a return made with the stack empty. Fetching and decoding instructions are left to neighbouring logic.

Top module: `pcseq_top`

## Requirements
- R1: While reset is held and after it is released, the PC reads 0 and the stack-error flag reads 0. Reset is asynchronous and active low, and its release takes effect two clock edges later.
- R2: On a clock edge where the advance strobe is low, neither the PC, the stack nor the error flag changes, whatever operation is presented.
- R3: Operation code 0 (sequential) sets the PC to PC+1, and 4095 is followed by 0.
- R4: Operation codes 1 (branch if zero set) and 2 (branch if zero clear) test the zero flag. When the test passes the PC becomes PC+1+disp, where disp is the 8-bit two's-complement displacement. When it fails the PC becomes PC+1.
- R5: Operation codes 3 (branch if carry set) and 4 (branch if carry clear) behave as in R4, but test the carry flag.
- R6: Operation code 5 (jump) loads the PC with the 12-bit absolute target, whatever the flags are.
- R7: Operation code 6 (call) pushes PC+1 and loads the target. Operation code 7 (return) pops the most recent saved address into the PC. Nesting works up to 8 levels and returns come back in last-in, first-out order.
- R8: A call made while 8 addresses are held sets the error flag, still loads the target, and discards the oldest saved address.
- R9: A return made with an empty stack sets the error flag and moves the PC to PC+1.
- R10: Once set, the error flag stays at 1 until reset.
- R11: All address arithmetic wraps modulo 4096. This includes backward branches that pass below address 0 and forward branches that pass above 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance strobe; the state changes only when this is high |
| op_i | input | 3 | Control-flow operation code (see R3 to R7) |
| disp_i | input | 8 | Signed branch displacement |
| target_i | input | 12 | Absolute jump or call address |
| zero_i | input | 1 | Zero flag |
| carry_i | input | 1 | Carry flag |
| pc_o | output | 12 | Current program counter |
| stk_err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
Each conditional branch is driven with its flag both passing and failing, so a swapped or inverted flag test shows up as a wrong PC. Positive, negative and zero displacements, applied near both ends of the address space, separate a measurement from the following instruction from one taken from the branch itself, and also test the wrap. Call chains of depth 3, 8 and 9 followed by matching returns check last-in, first-out order, the discard of the oldest entry on overflow, and the error on underflow. A call presented with the strobe low and then a return confirms that nothing was pushed.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BZ   = 3'd1,
    FLOW_BNZ  = 3'd2,
    FLOW_BC   = 3'd3,
    FLOW_BNC  = 3'd4,
    FLOW_JMP  = 3'd5,
    FLOW_CALL = 3'd6,
    FLOW_RET  = 3'd7
  } flow_op_e;
endpackage

// File: rtl/pcseq_next_addr.sv
module pcseq_next_addr
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DISP_W = 8
) (
  input  flow_op_e            op_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [ADDR_W-1:0]   target_i,
  input  logic                zero_i,
  input  logic                carry_i,
  input  logic [ADDR_W-1:0]   ret_addr_i,
  input  logic                stk_empty_i,
  input  logic                stk_full_i,
  output logic [ADDR_W-1:0]   next_pc_o,
  output logic [ADDR_W-1:0]   link_addr_o,
  output logic                push_o,
  output logic                pop_o,
  output logic                fault_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] rel_addr;
  logic              take;

  assign seq_addr    = pc_i + ADDR_W'(1);
  assign disp_ext    = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign rel_addr    = seq_addr + disp_ext;
  assign link_addr_o = seq_addr;

  always_comb begin
    take = 1'b0;
    unique case (op_i)
      FLOW_BZ:  take = zero_i;
      FLOW_BNZ: take = !zero_i;
      FLOW_BC:  take = carry_i;
      FLOW_BNC: take = !carry_i;
      default:  take = 1'b0;
    endcase
  end

  always_comb begin
    next_pc_o = seq_addr;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    fault_o   = 1'b0;
    unique case (op_i)
      FLOW_BZ, FLOW_BNZ, FLOW_BC, FLOW_BNC:
        next_pc_o = take ? rel_addr : seq_addr;
      FLOW_JMP:
        next_pc_o = target_i;
      FLOW_CALL: begin
        next_pc_o = target_i;
        push_o    = 1'b1;
        fault_o   = stk_full_i;
      end
      FLOW_RET: begin
        pop_o     = !stk_empty_i;
        fault_o   = stk_empty_i;
        next_pc_o = stk_empty_i ? seq_addr : ret_addr_i;
      end
      default:
        next_pc_o = seq_addr;
    endcase
  end
endmodule

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_data_i,
  output logic [ADDR_W-1:0] top_data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]     rd_ptr;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign do_push    = en_i && push_i;
  assign do_pop     = en_i && pop_i && (cnt_q != '0);
  assign rd_ptr     = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - PW'(1);
  assign top_data_o = slot_q[rd_ptr];
  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == FULL_CNT);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + PW'(1);
      if (!full_o) cnt_d = cnt_q + CW'(1);
    end else if (do_pop) begin
      wr_ptr_d = rd_ptr;
      cnt_d    = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_ptr_q] <= push_data_i;
  end

  // R8
  stk_depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R7
  stk_push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !full_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R2
  stk_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DISP_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [2:0]        op_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              zero_i,
  input  logic              carry_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              stk_err_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] next_pc, link_addr, ret_addr;
  logic              push, pop, fault, stk_empty, stk_full;
  flow_op_e          op;

  assign op = flow_op_e'(op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pcseq_next_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_next (
    .op_i        (op),
    .pc_i        (pc_q),
    .disp_i      (disp_i),
    .target_i    (target_i),
    .zero_i      (zero_i),
    .carry_i     (carry_i),
    .ret_addr_i  (ret_addr),
    .stk_empty_i (stk_empty),
    .stk_full_i  (stk_full),
    .next_pc_o   (next_pc),
    .link_addr_o (link_addr),
    .push_o      (push),
    .pop_o       (pop),
    .fault_o     (fault)
  );

  pcseq_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (adv_i),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (link_addr),
    .top_data_o  (ret_addr),
    .empty_o     (stk_empty),
    .full_o      (stk_full)
  );

  always_comb begin
    pc_d  = pc_q;
    err_d = err_q;
    if (adv_i) begin
      pc_d  = next_pc;
      err_d = err_q | fault;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_d;
    end
  end

  assign pc_o      = pc_q;
  assign stk_err_o = err_q;

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !adv_i |=> ($stable(pc_o) && $stable(stk_err_o)));

  // R3
  pc_seq_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_i && op_i == 3'd0) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));

  // R6
  pc_jump_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_i && op_i == 3'd5) |=> (pc_o == $past(target_i)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    stk_err_o |=> stk_err_o);

  // R9
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_i && op_i == 3'd7 && stk_empty) |=> stk_err_o);
endmodule

// File: tb/test_pcseq_top.sv
`timescale 1ns/1ps
module test_pcseq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i;
  logic [2:0]  op_i;
  logic [7:0]  disp_i;
  logic [11:0] target_i;
  logic        zero_i, carry_i;
  logic [11:0] pc_o;
  logic        stk_err_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [11:0] m_pc;
  logic        m_err;
  logic [11:0] m_stk [$];

  always #2.5 clk = ~clk;

  pcseq_top i_pcseq_top (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .op_i(op_i), .disp_i(disp_i),
    .target_i(target_i), .zero_i(zero_i), .carry_i(carry_i),
    .pc_o(pc_o), .stk_err_o(stk_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; adv_i = 1'b1; op_i = 3'd5; target_i = 12'd77;
    disp_i = '0; zero_i = 0; carry_i = 0;
    repeat (2) @(negedge clk);
    chk(tag, pc_o, 0, "pc in reset");
    rst_n = 1'b1; adv_i = 1'b0;
    repeat (3) @(negedge clk);
    m_pc = '0; m_err = 1'b0; m_stk.delete();
    chk(tag, pc_o, 0, "pc after reset");
    chk(tag, stk_err_o, 0, "err after reset");
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] d, input logic [11:0] t,
                      input logic z, input logic c, input logic a, input string tag);
    logic [11:0] seq;
    logic        take;
    op_i = op; disp_i = d; target_i = t; zero_i = z; carry_i = c; adv_i = a;
    if (a) begin
      seq  = m_pc + 12'd1;
      take = (op == 3'd1 && z) || (op == 3'd2 && !z) ||
             (op == 3'd3 && c) || (op == 3'd4 && !c);
      case (op)
        3'd5: m_pc = t;
        3'd6: begin
          if (m_stk.size() == 8) begin m_err = 1'b1; void'(m_stk.pop_front()); end
          m_stk.push_back(seq);
          m_pc = t;
        end
        3'd7: begin
          if (m_stk.size() == 0) begin m_err = 1'b1; m_pc = seq; end
          else m_pc = m_stk.pop_back();
        end
        default: m_pc = take ? seq + {{4{d[7]}}, d} : seq;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    adv_i = 1'b0;
    chk(tag, pc_o, m_pc, "pc");
    chk(tag, stk_err_o, m_err, "err");
  endtask

  task automatic t_reset;
    do_reset("R1");
  endtask

  task automatic t_hold;
    do_reset("R2");
    step(3'd5, 8'd0, 12'd300, 0, 0, 1, "R2");
    step(3'd5, 8'd0, 12'd900, 0, 0, 0, "R2");
    step(3'd6, 8'd0, 12'd500, 0, 0, 0, "R2");
    step(3'd0, 8'd0, 12'd0,   0, 0, 0, "R2");
    step(3'd7, 8'd0, 12'd0,   0, 0, 1, "R2");
  endtask

  task automatic t_seq_wrap;
    do_reset("R3");
    step(3'd0, 8'd0, 12'd0, 0, 0, 1, "R3");
    step(3'd5, 8'd0, 12'd4094, 0, 0, 1, "R6");
    step(3'd0, 8'd0, 12'd0, 0, 0, 1, "R3");
    step(3'd0, 8'd0, 12'd0, 0, 0, 1, "R3");
  endtask

  task automatic t_zero_branches;
    do_reset("R4");
    step(3'd5, 8'd0, 12'd100, 0, 0, 1, "R6");
    step(3'd1, 8'd5,   12'd0, 1, 0, 1, "R4");
    step(3'd1, 8'd5,   12'd0, 0, 1, 1, "R4");
    step(3'd2, 8'hFC,  12'd0, 0, 0, 1, "R4");
    step(3'd2, 8'hFC,  12'd0, 1, 0, 1, "R4");
    step(3'd1, 8'd0,   12'd0, 1, 0, 1, "R4");
    step(3'd2, 8'hFF,  12'd0, 0, 0, 1, "R4");
  endtask

  task automatic t_carry_branches;
    do_reset("R5");
    step(3'd5, 8'd0, 12'd200, 0, 0, 1, "R6");
    step(3'd3, 8'd10,  12'd0, 0, 1, 1, "R5");
    step(3'd3, 8'd10,  12'd0, 1, 0, 1, "R5");
    step(3'd4, 8'h80,  12'd0, 1, 0, 1, "R5");
    step(3'd4, 8'h80,  12'd0, 0, 1, 1, "R5");
  endtask

  task automatic t_jump_wrap;
    do_reset("R6");
    step(3'd5, 8'd0, 12'd4095, 1, 1, 1, "R6");
    step(3'd5, 8'd0, 12'd2,    0, 0, 1, "R6");
    step(3'd1, 8'h80, 12'd0, 1, 0, 1, "R11");
    step(3'd5, 8'd0, 12'd4090, 0, 0, 1, "R6");
    step(3'd3, 8'h7F, 12'd0, 0, 1, 1, "R11");
  endtask

  task automatic t_nested_calls;
    do_reset("R7");
    step(3'd6, 8'd0, 12'd100, 0, 0, 1, "R7");
    step(3'd6, 8'd0, 12'd200, 0, 0, 1, "R7");
    step(3'd0, 8'd0, 12'd0,   0, 0, 1, "R7");
    step(3'd6, 8'd0, 12'd300, 0, 0, 1, "R7");
    step(3'd7, 8'd0, 12'd0,   0, 0, 1, "R7");
    step(3'd7, 8'd0, 12'd0,   0, 0, 1, "R7");
    step(3'd7, 8'd0, 12'd0,   0, 0, 1, "R7");
    for (int i = 0; i < 8; i++) step(3'd6, 8'd0, 12'(16 * (i + 1)), 0, 0, 1, "R7");
    for (int i = 0; i < 8; i++) step(3'd7, 8'd0, 12'd0, 0, 0, 1, "R7");
  endtask

  task automatic t_overflow;
    do_reset("R8");
    for (int i = 0; i < 9; i++) step(3'd6, 8'd0, 12'(40 * (i + 1)), 0, 0, 1, "R8");
    for (int i = 0; i < 8; i++) step(3'd7, 8'd0, 12'd0, 0, 0, 1, "R8");
    step(3'd7, 8'd0, 12'd0, 0, 0, 1, "R9");
  endtask

  task automatic t_underflow_sticky;
    do_reset("R9");
    step(3'd5, 8'd0, 12'd60, 0, 0, 1, "R9");
    step(3'd7, 8'd0, 12'd0, 0, 0, 1, "R9");
    step(3'd6, 8'd0, 12'd10, 0, 0, 1, "R10");
    step(3'd7, 8'd0, 12'd0, 0, 0, 1, "R10");
    step(3'd0, 8'd0, 12'd0, 0, 0, 1, "R10");
    do_reset("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; adv_i = 1'b0; op_i = '0; disp_i = '0; target_i = '0;
    zero_i = 1'b0; carry_i = 1'b0;
    m_pc = '0; m_err = 1'b0;
    t_reset();
    t_hold();
    t_seq_wrap();
    t_zero_branches();
    t_carry_branches();
    t_jump_wrap();
    t_nested_calls();
    t_overflow();
    t_underflow_sticky();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule